// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether a 10 Mb/s twisted-pair receive channel has a working partner. The analog front end reports what it sees as single-cycle strobes: one for a normal link pulse and one for received packet activity. A free-running strobe marks each millisecond.

If no strobe of either kind arrives for a programmable number of milliseconds, the monitor declares the link down. The link comes back at once when any packet activity is seen. Without packet activity, it comes back after a programmable number of link pulses, counted while the link is down.

The monitor drives four enables for the transmit, loopback, collision-detect and SQE paths. While the link is down, all four are held low. The inactivity timeout and the pulse count are parameters, so a simulation can use small values.

Top module: `lnk_integrity_mon`

## Requirements
- R1: After reset, `link_ok` is 0 and all four enables are 0.
- R2: When the link is up, `link_ok` falls at the clock edge that samples the TIMEOUT_MS-th `ms_tick` with no pulse or data strobe since the last such strobe, and not before.
- R3: Every `pulse_seen` or `data_seen` strobe restarts the inactivity count from zero, so the next TIMEOUT_MS-1 ticks do not drop the link.
- R4: A `data_seen` strobe sets `link_ok` at the same clock edge that samples it, whatever the pulse count is, and a strobe while up keeps the link up.
- R5: While the link is down, the edge that samples the PULSES_UP-th `pulse_seen` strobe sets `link_ok`; fewer pulses leave it at 0, and `ms_tick` strobes do not clear the pulses already counted.
- R6: The pulse count restarts from zero each time the link comes up, whether by pulses or by data, so a later recovery again needs PULSES_UP pulses.
- R7: `tx_ena`, `lpbk_ena`, `coll_ena` and `sqe_ena` are each 1 exactly when `link_ok` is 1.
- R8: If a pulse or data strobe and the expiring tick are sampled at the same edge, the link stays up and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| pulse_seen | input | 1 | One-cycle strobe per received normal link pulse |
| data_seen | input | 1 | One-cycle strobe for received packet activity |
| link_ok | output | 1 | Link status, 1 when up |
| tx_ena | output | 1 | Transmit path enable |
| lpbk_ena | output | 1 | Loopback path enable |
| coll_ena | output | 1 | Collision-detect enable |
| sqe_ena | output | 1 | SQE test enable |

## Verification
Every result is due one edge after its cause. The link state is the only register between a strobe and the outputs, so a strobe sampled at one edge shows on `link_ok` and on the enables right after that edge. The bench drives each strobe for exactly one cycle starting at a falling edge, and reads the outputs at the next falling edge, after the rising edge that consumed the strobe. The timeout and pulse-count sweeps walk every tick index from 1 to TIMEOUT_MS and every pulse index from 1 to PULSES_UP, and at each step compare against the value the index implies.

// File: rtl/lim_pkg.sv
package lim_pkg;
   typedef enum logic {
      LNK_DOWN = 1'b0,
      LNK_UP   = 1'b1
   } lnk_state_e;

   function automatic int unsigned cnt_width(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction
endpackage

// File: rtl/lim_idle_timer.sv
module lim_idle_timer #(
   parameter int unsigned TIMEOUT_MS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic activity,
   output logic expire
);
   localparam int unsigned TW = lim_pkg::cnt_width(TIMEOUT_MS);
   localparam logic [TW-1:0] LAST = TW'(TIMEOUT_MS - 1);
   localparam logic [TW-1:0] FULL = TW'(TIMEOUT_MS);

   logic [TW-1:0] idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         idle_q <= '0;
      else if (activity)                  idle_q <= '0;
      else if (ms_tick && idle_q != FULL) idle_q <= idle_q + 1'b1;
   end

   assign expire = ms_tick && !activity && (idle_q == LAST);
endmodule

// File: rtl/lim_pulse_counter.sv
module lim_pulse_counter #(
   parameter int unsigned PULSES_UP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse,
   input  logic clear,
   input  logic armed,
   output logic enough
);
   localparam int unsigned PW = lim_pkg::cnt_width(PULSES_UP);

   generate
      if (PULSES_UP == 1) begin : g_single
         assign enough = armed && pulse;
      end else begin : g_count
         localparam logic [PW-1:0] LAST = PW'(PULSES_UP - 1);
         logic [PW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (clear)          cnt_q <= '0;
            else if (armed && pulse) cnt_q <= cnt_q + 1'b1;
         end
         assign enough = armed && pulse && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/lim_link_fsm.sv
module lim_link_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic data_in,
   input  logic pulses_done,
   input  logic expire,
   output logic going_up,
   output logic up
);
   import lim_pkg::*;
   lnk_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         LNK_DOWN: if (data_in || pulses_done) st_d = LNK_UP;
         LNK_UP:   if (expire)                 st_d = LNK_DOWN;
         default:                              st_d = LNK_DOWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LNK_DOWN;
      else        st_q <= st_d;
   end

   assign going_up = (st_q == LNK_DOWN) && (st_d == LNK_UP);
   assign up       = (st_q == LNK_UP);
endmodule

// File: rtl/lnk_integrity_mon.sv
module lnk_integrity_mon #(
   parameter int unsigned TIMEOUT_MS = 64,
   parameter int unsigned PULSES_UP  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic pulse_seen,
   input  logic data_seen,
   output logic link_ok,
   output logic tx_ena,
   output logic lpbk_ena,
   output logic coll_ena,
   output logic sqe_ena
);
   initial begin
      if (TIMEOUT_MS < 2) $error("TIMEOUT_MS must be at least 2");
      if (PULSES_UP < 1)  $error("PULSES_UP must be at least 1");
   end

   logic activity, expire, enough, going_up, up;

   assign activity = pulse_seen || data_seen;

   lim_idle_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_timer (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
      .activity(activity), .expire(expire)
   );

   lim_pulse_counter #(.PULSES_UP(PULSES_UP)) u_pcnt (
      .clk(clk), .rst_n(rst_n), .pulse(pulse_seen),
      .clear(going_up || up), .armed(!up), .enough(enough)
   );

   lim_link_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .data_in(data_seen),
      .pulses_done(enough), .expire(expire),
      .going_up(going_up), .up(up)
   );

   assign link_ok  = up;
   assign tx_ena   = up;
   assign lpbk_ena = up;
   assign coll_ena = up;
   assign sqe_ena  = up;
endmodule

// File: rtl/lim_checker.sv
module lim_checker #(
   parameter int unsigned TIMEOUT_MS = 64,
   parameter int unsigned PULSES_UP  = 4
) (
   input logic clk,
   input logic rst_n,
   input logic ms_tick,
   input logic pulse_seen,
   input logic data_seen,
   input logic link_ok,
   input logic tx_ena,
   input logic lpbk_ena,
   input logic coll_ena,
   input logic sqe_ena
);
   int unsigned idle_ref, pul_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_ref <= 0;
         pul_ref  <= 0;
      end else begin
         if (pulse_seen || data_seen)                idle_ref <= 0;
         else if (ms_tick && idle_ref < TIMEOUT_MS)  idle_ref <= idle_ref + 1;
         if (link_ok || data_seen)                   pul_ref <= 0;
         else if (pulse_seen)                        pul_ref <= pul_ref + 1;
      end
   end

   AST_DROP_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_ok) |-> ($past(ms_tick) && $past(idle_ref) == TIMEOUT_MS - 1)); // R2
   AST_EVENT_KEEPS_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (link_ok && (pulse_seen || data_seen)) |=> link_ok); // R8
   AST_DATA_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      data_seen |=> link_ok); // R4
   AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_ok) |-> ($past(data_seen) ||
         ($past(pulse_seen) && $past(pul_ref) == PULSES_UP - 1))); // R5
   AST_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !link_ok |-> !(tx_ena || lpbk_ena || coll_ena || sqe_ena)); // R7
   AST_GATES_ON: assert property (@(posedge clk) disable iff (!rst_n)
      link_ok |-> (tx_ena && lpbk_ena && coll_ena && sqe_ena)); // R7
endmodule

bind lnk_integrity_mon lim_checker #(.TIMEOUT_MS(TIMEOUT_MS), .PULSES_UP(PULSES_UP)) u_chk (
   .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pulse_seen(pulse_seen),
   .data_seen(data_seen), .link_ok(link_ok), .tx_ena(tx_ena),
   .lpbk_ena(lpbk_ena), .coll_ena(coll_ena), .sqe_ena(sqe_ena)
);

// File: tb/lnk_integrity_mon_test.sv
`timescale 1ns/1ps
module lnk_integrity_mon_test;
   localparam int T = 5;
   localparam int P = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ms_tick = 1'b0, pulse_seen = 1'b0, data_seen = 1'b0;
   logic link_ok, tx_ena, lpbk_ena, coll_ena, sqe_ena;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lnk_integrity_mon #(.TIMEOUT_MS(T), .PULSES_UP(P)) uut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pulse_seen(pulse_seen),
      .data_seen(data_seen), .link_ok(link_ok), .tx_ena(tx_ena),
      .lpbk_ena(lpbk_ena), .coll_ena(coll_ena), .sqe_ena(sqe_ena)
   );

   task automatic chk(input bit exp, input string req);
      checks++;
      if (link_ok !== exp) begin
         fails++;
         $display("FAIL %s link_ok actual=%b expected=%b", req, link_ok, exp);
      end
      checks++;
      if ({tx_ena, lpbk_ena, coll_ena, sqe_ena} !== {4{exp}}) begin
         fails++;
         $display("FAIL R7 (%s) enables actual=%b expected=%b", req,
                  {tx_ena, lpbk_ena, coll_ena, sqe_ena}, {4{exp}});
      end
   endtask

   // drive one cycle of strobes from a falling edge; return at the next falling edge
   task automatic step(input bit t, input bit p, input bit d);
      @(negedge clk);
      ms_tick = t; pulse_seen = p; data_seen = d;
      @(negedge clk);
      ms_tick = 1'b0; pulse_seen = 1'b0; data_seen = 1'b0;
   endtask

   task automatic timeout_sweep(input string req);
      for (int k = 1; k <= T; k++) begin
         step(1, 0, 0);
         chk(k < T, req);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk(0, "R1");
      // pulse sweep from reset, ticks interleaved must not lose count (R5)
      for (int n = 1; n <= P; n++) begin
         step(1, 0, 0);
         chk(0, "R5");
         step(0, 1, 0);
         chk(n == P, "R5");
      end
      timeout_sweep("R2");
      for (int k = 0; k < 3; k++) begin step(1, 0, 0); chk(0, "R2"); end
      // counter restarted after pulse recovery (R6)
      for (int n = 1; n <= P; n++) begin step(0, 1, 0); chk(n == P, "R6"); end
      timeout_sweep("R2");
      // data recovery with partial pulse count (R4)
      step(0, 1, 0); chk(0, "R5");
      step(0, 0, 1); chk(1, "R4");
      step(0, 0, 1); chk(1, "R4");
      timeout_sweep("R2");
      // counter restarted after data recovery (R6)
      for (int n = 1; n <= P; n++) begin step(0, 1, 0); chk(n == P, "R6"); end
      // restart by pulse and by data (R3)
      for (int e = 0; e < 2; e++) begin
         for (int k = 1; k < T; k++) begin step(1, 0, 0); chk(1, "R3"); end
         step(0, e == 0, e == 1); chk(1, "R3");
         timeout_sweep("R3");
         step(0, 0, 1); chk(1, "R4");
      end
      // event coincides with expiring tick (R8)
      for (int e = 0; e < 2; e++) begin
         for (int k = 1; k < T; k++) begin step(1, 0, 0); chk(1, "R8"); end
         step(1, e == 0, e == 1); chk(1, "R8");
         timeout_sweep("R8");
         step(0, 0, 1); chk(1, "R4");
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule